// File: doc/BRIEF.md
# Fixed-Latency Load Return Buffer

This block sits between a statically scheduled pipeline and a memory system whose response time varies. Software loads a latency register with the load-to-use distance that the compiler assumed. The block then makes every load appear to take exactly that many cycles. Data that comes back early is parked in a slot until its due cycle. If data is still missing when its due cycle arrives, the block holds the pipeline with a stall until the data shows up.

Each accepted load takes a slot from a circular ring. The slot index goes out with the load as the memory tag, and memory returns it with the data. Each slot keeps the latency in force when its load issued and counts it down only in cycles when the pipeline is not stalled. Slots are written back strictly in issue order, whatever order memory uses to return them.

Top module: `fixed_latency_load_buffer`

## Requirements
- R1: After reset there is no writeback and no stall, `iss_ready` is 1, `iss_slot` is 0, and the latency register holds `RST_LAT`.
- R2: When memory answers in time and no stall intervenes, a load accepted in cycle c is written back in cycle c+L, where L is the latency that applied at its issue.
- R3: Data that returns before its due cycle is held in its slot. It is written back unchanged, together with the destination id given at issue.
- R4: When data is missing at its due cycle, `stall` is 1 from that cycle until the response arrives. In the response cycle `stall` is 0 and the data is written back straight from the response port.
- R5: Stalled cycles do not count towards any outstanding load, so every later load's writeback moves back by the number of stall cycles.
- R6: Writebacks follow issue order even when responses arrive in a different order.
- R7: At most SLOTS loads are outstanding. `iss_ready` is 0 while all slots are busy or while `stall` is 1, and an issue request made while `iss_ready` is 0 is dropped.
- R8: A latency write in cycle w applies only to loads issued in cycles after w. A load issued in cycle w uses the previous value.
- R9: Writing 0 to the latency register gives a latency of 1.
- R10: A response whose tag names a free slot, or a slot that already holds data, is ignored.
- R11: `iss_slot` gives the slot for the next load. It starts at 0 and advances by one, modulo SLOTS, for every accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_we | input | 1 | Latency register write strobe |
| lat_wdata | input | LAT_W | New latency in cycles |
| iss_valid | input | 1 | Load issue request |
| iss_dst | input | DST_W | Destination id carried with the load |
| iss_ready | output | 1 | Issue accepted this cycle if requested |
| iss_slot | output | IDX_W | Tag the issued load sends to memory |
| rsp_valid | input | 1 | Memory response valid |
| rsp_tag | input | IDX_W | Slot tag of the response |
| rsp_data | input | DATA_W | Response data |
| wb_valid | output | 1 | Writeback to the pipeline this cycle |
| wb_dst | output | DST_W | Destination id of the writeback |
| wb_data | output | DATA_W | Writeback data |
| stall | output | 1 | Pipeline hold while due data is missing |

## Verification
The bench builds the block with 8 slots, 16-bit data, 4-bit destination ids, a 5-bit latency field and a reset latency of 3. With these sizes it can sweep every latency from 1 to 6 against every response delay from one cycle after issue to three cycles past due. That sweep covers the early, exact and late boundaries, and the expected writeback cycle and stall count for each case are computed as plain arithmetic. The small ring can also be filled completely and its tags wrapped, and the bench covers reversed return order, a stall pushing back a younger load, latency writes that coincide with an issue, and stray responses.

// File: rtl/fllb_pkg.sv
package fllb_pkg;

    // Condition of the oldest outstanding slot in a given cycle.
    typedef enum logic [1:0] {
        HEAD_EMPTY = 2'd0,  // nothing outstanding
        HEAD_WAIT  = 2'd1,  // outstanding, not yet due
        HEAD_GO    = 2'd2,  // due and data available: write back
        HEAD_LATE  = 2'd3   // due and data missing: hold the pipeline
    } head_st_e;

    function automatic head_st_e head_state(logic live, logic due, logic avail);
        if (!live)  return HEAD_EMPTY;
        if (!due)   return HEAD_WAIT;
        if (avail)  return HEAD_GO;
        return HEAD_LATE;
    endfunction

    // Successor of a ring index for a ring of n entries.
    function automatic int unsigned ring_next(int unsigned p, int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/fllb_lat_reg.sv
module fllb_lat_reg #(
    parameter int LAT_W   = 6,
    parameter int RST_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] wr_val,
    output logic [LAT_W-1:0] lat_q
);
    localparam logic [LAT_W-1:0] RST_VAL = (RST_LAT == 0) ? LAT_W'(1) : LAT_W'(RST_LAT);

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= RST_VAL;
        else if (wr_en)
            lat_q <= (wr_val == '0) ? LAT_W'(1) : wr_val;
    end

    // R9: the stored latency is never zero
    a_r9_lat_nonzero: assert property (@(posedge clk) disable iff (rst)
        lat_q != '0);

endmodule

// File: rtl/fllb_ring.sv
module fllb_ring #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) tail <= IDX_W'(fllb_pkg::ring_next(int'(tail), SLOTS));
            if (pop)  head <= IDX_W'(fllb_pkg::ring_next(int'(head), SLOTS));
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign full  = (cnt_q == CNT_W'(SLOTS));
    assign empty = (cnt_q == '0);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(SLOTS));
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/fllb_slot_bank.sv
module fllb_slot_bank #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 32,
    parameter int DST_W  = 5,
    parameter int LAT_W  = 6,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [DST_W-1:0]  alloc_dst,
    input  logic [LAT_W-1:0]  alloc_rem,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              tick,
    input  logic              release_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_live,
    output logic              rd_has,
    output logic              rd_due,
    output logic [DST_W-1:0]  rd_dst,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              live;
        logic              has_data;
        logic [LAT_W-1:0]  rem;
        logic [DST_W-1:0]  dst;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (release_en && rd_idx == ME) begin
                slot_q[i].live     <= 1'b0;
                slot_q[i].has_data <= 1'b0;
            end else if (alloc && alloc_idx == ME) begin
                slot_q[i].live     <= 1'b1;
                slot_q[i].has_data <= 1'b0;
                slot_q[i].rem      <= alloc_rem;
                slot_q[i].dst      <= alloc_dst;
            end else if (slot_q[i].live) begin
                if (fill_en && fill_idx == ME && !slot_q[i].has_data) begin
                    slot_q[i].has_data <= 1'b1;
                    slot_q[i].data     <= fill_data;
                end
                if (tick && slot_q[i].rem != '0)
                    slot_q[i].rem <= slot_q[i].rem - LAT_W'(1);
            end
        end

        // R10: a response to a free slot does not make it hold data
        a_r10_stray_fill: assert property (@(posedge clk) disable iff (rst)
            (fill_en && fill_idx == ME && !slot_q[i].live && !(alloc && alloc_idx == ME))
            |=> !slot_q[i].has_data);

        // R5: a frozen timebase leaves the countdown untouched
        a_r5_frozen_count: assert property (@(posedge clk) disable iff (rst)
            (!tick && slot_q[i].live && !(release_en && rd_idx == ME))
            |=> $stable(slot_q[i].rem));
    end

    always_comb begin
        rd_live = slot_q[rd_idx].live;
        rd_has  = slot_q[rd_idx].has_data;
        rd_due  = (slot_q[rd_idx].rem == '0);
        rd_dst  = slot_q[rd_idx].dst;
        rd_data = slot_q[rd_idx].data;
    end

endmodule

// File: rtl/fixed_latency_load_buffer.sv
module fixed_latency_load_buffer #(
    parameter int SLOTS   = 8,
    parameter int DATA_W  = 32,
    parameter int DST_W   = 5,
    parameter int LAT_W   = 6,
    parameter int RST_LAT = 4,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_we,
    input  logic [LAT_W-1:0]  lat_wdata,
    input  logic              iss_valid,
    input  logic [DST_W-1:0]  iss_dst,
    output logic              iss_ready,
    output logic [IDX_W-1:0]  iss_slot,
    input  logic              rsp_valid,
    input  logic [IDX_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [DST_W-1:0]  wb_dst,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);
    import fllb_pkg::*;

    logic [LAT_W-1:0]  lat_q;
    logic [IDX_W-1:0]  head, tail;
    logic              full, empty;
    logic              push, pop;
    logic              rd_live, rd_has, rd_due;
    logic [DST_W-1:0]  rd_dst;
    logic [DATA_W-1:0] rd_data;
    logic              rsp_hit;
    head_st_e          head_st;

    fllb_lat_reg #(.LAT_W(LAT_W), .RST_LAT(RST_LAT)) u_lat (
        .clk(clk), .rst(rst), .wr_en(lat_we), .wr_val(lat_wdata), .lat_q(lat_q)
    );

    fllb_ring #(.SLOTS(SLOTS)) u_ring (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    fllb_slot_bank #(.SLOTS(SLOTS), .DATA_W(DATA_W), .DST_W(DST_W), .LAT_W(LAT_W)) u_bank (
        .clk(clk), .rst(rst),
        .alloc(push), .alloc_idx(tail), .alloc_dst(iss_dst), .alloc_rem(lat_q - LAT_W'(1)),
        .fill_en(rsp_valid), .fill_idx(rsp_tag), .fill_data(rsp_data),
        .tick(!stall), .release_en(pop), .rd_idx(head),
        .rd_live(rd_live), .rd_has(rd_has), .rd_due(rd_due),
        .rd_dst(rd_dst), .rd_data(rd_data)
    );

    // A response for the due head slot is passed straight to writeback.
    assign rsp_hit = rsp_valid && (rsp_tag == head) && rd_live && !rd_has;
    assign head_st = head_state(rd_live, rd_due, rd_has || rsp_hit);

    assign wb_valid  = (head_st == HEAD_GO);
    assign stall     = (head_st == HEAD_LATE);
    assign wb_dst    = rd_dst;
    assign wb_data   = rd_has ? rd_data : rsp_data;
    assign pop       = wb_valid;
    assign iss_ready = !full && !stall;
    assign push      = iss_valid && iss_ready;
    assign iss_slot  = tail;

    // R4: a stall ends only in a writeback
    a_r4_stall_until_data: assert property (@(posedge clk) disable iff (rst)
        stall |=> (stall || wb_valid));
    // R5: the oldest slot is held while stalling
    a_r5_head_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(head));
    // R2: writeback only from a live slot whose count has run out
    a_r2_wb_on_due: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (rd_live && rd_due));
    // R6: nothing is written back while the ring is empty
    a_r6_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        empty |-> (!wb_valid && !stall));

endmodule

// File: tb/fixed_latency_load_buffer_tb.sv
`timescale 1ns/1ps
module fixed_latency_load_buffer_tb;
    localparam int SLOTS = 8, DATA_W = 16, DST_W = 4, LAT_W = 5, RST_LAT = 3;
    localparam int IDX_W = $clog2(SLOTS);

    logic clk = 1'b0, rst = 1'b1;
    logic lat_we = 0;            logic [LAT_W-1:0] lat_wdata = '0;
    logic iss_valid = 0;         logic [DST_W-1:0] iss_dst = '0;
    logic iss_ready;             logic [IDX_W-1:0] iss_slot;
    logic rsp_valid = 0;         logic [IDX_W-1:0] rsp_tag = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic wb_valid, stall;       logic [DST_W-1:0] wb_dst;
    logic [DATA_W-1:0] wb_data;

    fixed_latency_load_buffer #(.SLOTS(SLOTS), .DATA_W(DATA_W), .DST_W(DST_W),
        .LAT_W(LAT_W), .RST_LAT(RST_LAT)) u_dut (
        .clk(clk), .rst(rst), .lat_we(lat_we), .lat_wdata(lat_wdata),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_ready(iss_ready), .iss_slot(iss_slot),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data), .stall(stall));

    always #2.5 clk = ~clk;

    int cyc = 0, n_chk = 0, n_fail = 0, wb_n = 0, stall_n = 0;
    bit done = 0;
    int wb_cyc [512];
    logic [DST_W-1:0]  wb_dst_l [512];
    logic [DATA_W-1:0] wb_dat_l [512];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (!rst) begin
        if (wb_valid && wb_n < 512) begin
            wb_cyc[wb_n] = cyc; wb_dst_l[wb_n] = wb_dst; wb_dat_l[wb_n] = wb_data;
            wb_n++;
        end
        if (stall) stall_n++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) step();
    endtask

    task automatic set_lat(input int v);
        lat_we = 1; lat_wdata = LAT_W'(v); step(); lat_we = 0;
    endtask

    task automatic issue(input int dst, output int c, output int slot);
        iss_valid = 1; iss_dst = DST_W'(dst); c = cyc; slot = int'(iss_slot);
        step(); iss_valid = 0;
    endtask

    task automatic respond(input int tag, input int data);
        rsp_valid = 1; rsp_tag = IDX_W'(tag); rsp_data = DATA_W'(data);
        step(); rsp_valid = 0;
    endtask

    task automatic check_wb(input int idx, input int ec, input int ed, input int ev,
                            input string req);
        chk(wb_n > idx, req, "writeback count", wb_n, idx + 1);
        if (wb_n > idx) begin
            chk(wb_cyc[idx] == ec, req, "writeback cycle", wb_cyc[idx], ec);
            chk(int'(wb_dst_l[idx]) == ed, req, "writeback dst", wb_dst_l[idx], ed);
            chk(int'(wb_dat_l[idx]) == ev, req, "writeback data", wb_dat_l[idx], ev);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (run did not end): actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int c, s, b, s0, c0, sa, sb, ca, cb, nb;
        repeat (3) step();
        rst = 0;
        step();
        // R1: reset state
        chk(!wb_valid, "R1", "wb_valid", wb_valid, 0);
        chk(!stall, "R1", "stall", stall, 0);
        chk(iss_ready, "R1", "iss_ready", iss_ready, 1);
        chk(iss_slot == 0, "R1", "iss_slot", iss_slot, 0);
        b = wb_n;
        issue(5, c, s);
        respond(s, 16'h0A5A);
        wait_until(c + RST_LAT + 3);
        check_wb(b, c + RST_LAT, 5, 16'h0A5A, "R1");

        // R2 R3 R4: sweep latency against response delay
        for (int L = 1; L <= 6; L++) begin
            for (int d = 1; d <= L + 3; d++) begin
                int st0, due;
                set_lat(L);
                b = wb_n; st0 = stall_n;
                issue((L + d) % 16, c, s);
                wait_until(c + d);
                respond(s, L * 100 + d);
                due = (d > L) ? d : L;
                wait_until(c + due + 3);
                check_wb(b, c + due, (L + d) % 16, L * 100 + d, (d < L) ? "R3" : (d == L ? "R2" : "R4"));
                chk(stall_n - st0 == ((d > L) ? d - L : 0), "R4", "stall cycles",
                    stall_n - st0, (d > L) ? d - L : 0);
            end
        end

        // R5: stall of the older load pushes the younger one back
        set_lat(4);
        b = wb_n;
        issue(1, ca, sa);
        issue(2, cb, sb);
        respond(sb, 16'h0B0B);
        wait_until(ca + 5);
        chk(stall, "R4", "stall while late", stall, 1);
        chk(!iss_ready, "R7", "iss_ready during stall", iss_ready, 0);
        wait_until(ca + 7);
        respond(sa, 16'h0A0A);
        wait_until(ca + 12);
        check_wb(b, ca + 7, 1, 16'h0A0A, "R4");
        check_wb(b + 1, ca + 8, 2, 16'h0B0B, "R5");

        // R6: reversed return order, delivered in issue order
        set_lat(8);
        b = wb_n;
        begin
            int cs [4]; int ss [4];
            for (int k = 0; k < 4; k++) issue(k + 1, cs[k], ss[k]);
            for (int k = 3; k >= 0; k--) respond(ss[k], 16'h0600 + k);
            wait_until(cs[0] + 14);
            for (int k = 0; k < 4; k++)
                check_wb(b + k, cs[0] + 8 + k, k + 1, 16'h0600 + k, "R6");
        end

        // R7 R11: fill the ring, refuse a ninth load, slot tags advance and wrap
        set_lat(20);
        b = wb_n;
        s0 = int'(iss_slot);
        c0 = cyc;
        for (int k = 0; k < SLOTS; k++) begin
            chk(iss_ready, "R7", "iss_ready below full", iss_ready, 1);
            chk(int'(iss_slot) == (s0 + k) % SLOTS, "R11", "slot tag", iss_slot, (s0 + k) % SLOTS);
            issue(k, c, s);
        end
        chk(!iss_ready, "R7", "iss_ready when full", iss_ready, 0);
        issue(15, c, s);
        for (int k = 0; k < SLOTS; k++) respond((s0 + k) % SLOTS, 16'h0100 + k);
        wait_until(c0 + 20 + SLOTS + 4);
        chk(wb_n - b == SLOTS, "R7", "loads delivered", wb_n - b, SLOTS);
        for (int k = 0; k < SLOTS; k++)
            check_wb(b + k, c0 + 20 + k, k, 16'h0100 + k, "R7");
        chk(int'(iss_slot) == s0, "R11", "slot tag after wrap", iss_slot, s0);

        // R8: latency written in the issue cycle applies to the next load only
        set_lat(2);
        b = wb_n;
        lat_we = 1; lat_wdata = 7;
        issue(3, ca, sa);
        lat_we = 0;
        issue(4, cb, sb);
        respond(sa, 16'h0808);
        respond(sb, 16'h0909);
        wait_until(cb + 10);
        check_wb(b, ca + 2, 3, 16'h0808, "R8");
        check_wb(b + 1, cb + 7, 4, 16'h0909, "R8");

        // R9: zero latency behaves as one
        set_lat(0);
        b = wb_n;
        issue(6, c, s);
        respond(s, 16'h0909);
        wait_until(c + 4);
        check_wb(b, c + 1, 6, 16'h0909, "R9");

        // R10: stray response to a free slot, duplicate response to a filled slot
        set_lat(3);
        b = wb_n;
        respond(int'(iss_slot), 16'hDEAD);
        step();
        chk(wb_n == b, "R10", "no writeback from stray response", wb_n - b, 0);
        issue(7, c, s);
        wait_until(c + 5);
        respond(s, 16'h1234);
        wait_until(c + 8);
        check_wb(b, c + 5, 7, 16'h1234, "R10");
        set_lat(5);
        nb = wb_n;
        issue(8, c, s);
        respond(s, 16'h4321);
        respond(s, 16'hBEEF);
        wait_until(c + 8);
        check_wb(nb, c + 5, 8, 16'h4321, "R10");
        chk(wb_n == nb + 1, "R10", "single writeback", wb_n - nb, 1);

        done = 1;
        finish_run();
    end
endmodule